// File: doc/BRIEF.md
# Interrupt translator register frontend

This block is the memory-mapped register face of a message-based interrupt translation unit. It decodes single accesses of 1, 2, 4 or 8 bytes into a 64 KB register frame. It holds the one writable bit of the frame, the translator enable, and drives that bit out to the command engine. It also returns the fixed capability, implementer and identification words.

The command queue pointer registers belong to a separate command engine. That engine feeds its read pointer, its write pointer and a fetch-busy flag into this block. The frontend uses them only to report whether the engine is idle. Reads return data one cycle after the request. The addressed bytes are shifted down to bit 0, and everything above the access size is zero.

Top module: `itrf_regfront`

## Requirements
- R1: A synchronous active-high reset clears the enable bit, so `its_enable` is 0 and `rd_valid` is 0 after reset.
- R2: A write whose address is exactly 0x0000 (any size) loads `acc_wdata[0]` into the enable bit. `its_enable` shows the new value from the cycle after the write.
- R3: A write to any other address, including 0x0001 to 0x0003 of the control word, leaves the enable bit unchanged.
- R4: The control word (offset 0x0000) reads enable in bit 0 and the idle flag in bit 31. Bit 31 is 1 exactly when `eng_rptr` equals `eng_wptr` and `eng_fetch_busy` is 0, sampled in the request cycle. All other bits read 0.
- R5: The capability word at 0x0008 to 0x000F reads 0x00000000FF01EF01 and ignores writes. This value has bit 0 set (physical LPI support), identifier bits 0x0F at bit 8, device bits 0x0F at bit 13, bit 19 clear (linear processor numbering) and a collection count of 0xFF at bit 24.
- R6: The implementer word at 0x0004 reads the product ID in bits [31:24] and the implementer code in bits [11:0] (default 0x4B00043B). Writes to it are ignored.
- R7: The identification block reads these values: 0x40 at 0xFFD0 (64 KB page), 0x30 at 0xFFE8 (architecture revision), and 0x0D, 0xF0, 0x05, 0xB1 at 0xFFF0, 0xFFF4, 0xFFF8, 0xFFFC.
- R8: Any other identification offset from 0xFFD0 to 0xFFFF, and every unmapped address, reads as zero.
- R9: A read returns the register shifted right by 8 times the byte offset inside the register, masked to 1 << `acc_size` bytes. The offset is the low 2 address bits for 4-byte registers and the low 3 bits for the capability word. The size codes are 0 for 1 byte, 1 for 2, 2 for 4 and 3 for 8. Registers of 4 bytes are zero-extended.
- R10: `rd_valid` is 1 exactly in the cycle after a read request. `rd_data` is zero whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 16 | Byte offset into the register frame |
| acc_size | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| acc_wdata | input | 64 | Write data, right-aligned |
| eng_rptr | input | 15 | Command engine read pointer |
| eng_wptr | input | 15 | Command engine write pointer |
| eng_fetch_busy | input | 1 | Command engine has a fetch outstanding |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Aligned read data |
| its_enable | output | 1 | Translator enable to the command engine |

## Verification
Directed reads cover every mapped word at its base address. These tell an address decode fault apart from a wrong constant. Narrow reads at odd byte offsets of the capability and control words separate the shift amount from the size mask. Writes aimed at every region, with random data, separate the single writable bit from locations that must ignore writes. Random pointer pairs, in which about half are equal and the busy flag is random, show whether the idle flag needs both conditions rather than either one.

// File: rtl/itrf_pkg.sv
package itrf_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_IIDR,
        RG_TYPER,
        RG_IDB
    } itrf_region_e;

    localparam logic [15:0] OFS_CTRL  = 16'h0000;
    localparam logic [15:0] OFS_IIDR  = 16'h0004;
    localparam logic [15:0] OFS_TYPER = 16'h0008;
    localparam logic [15:0] OFS_IDB   = 16'hFFD0;

    typedef struct packed {
        logic        en;
        logic        rvalid;
        logic [63:0] rdata;
    } itrf_state_t;

    // Byte mask for an access size code: 1, 2, 4 or 8 bytes.
    function automatic logic [63:0] itrf_size_mask(input logic [1:0] sz);
        logic [63:0] m;
        case (sz)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/itrf_decode.sv
module itrf_decode
    import itrf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output itrf_region_e      region,
    output logic [2:0]        boff,
    output logic [3:0]        id_idx
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_IIDR  = ADDR_W'(OFS_IIDR);
    localparam logic [ADDR_W-1:0] A_TYPER = ADDR_W'(OFS_TYPER);
    localparam logic [ADDR_W-1:0] A_IDB   = ADDR_W'(OFS_IDB);

    logic [ADDR_W-1:0] id_rel;

    always_comb begin
        region = RG_NONE;
        boff   = {1'b0, addr[1:0]};
        id_rel = addr - A_IDB;
        id_idx = id_rel[5:2];
        if (addr[ADDR_W-1:2] == A_CTRL[ADDR_W-1:2]) begin
            region = RG_CTRL;
        end else if (addr[ADDR_W-1:2] == A_IIDR[ADDR_W-1:2]) begin
            region = RG_IIDR;
        end else if (addr[ADDR_W-1:3] == A_TYPER[ADDR_W-1:3]) begin
            region = RG_TYPER;
            boff   = addr[2:0];
        end else if (addr >= A_IDB) begin
            region = RG_IDB;
        end
    end

endmodule

// File: rtl/itrf_idrom.sv
module itrf_idrom #(
    parameter logic [7:0] PART2_VAL = 8'h30,
    parameter int         N_WORDS   = 12
) (
    input  logic [3:0]  idx,
    output logic [31:0] val
);

    function automatic logic [7:0] id_byte(input int i);
        logic [7:0] b;
        case (i)
            0:       b = 8'h40;       // page size word
            6:       b = PART2_VAL;   // architecture revision word
            8:       b = 8'h0D;
            9:       b = 8'hF0;
            10:      b = 8'h05;
            11:      b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    logic [31:0] rom [N_WORDS];

    generate
        for (genvar g = 0; g < N_WORDS; g++) begin : g_ent
            assign rom[g] = {24'h0, id_byte(g)};
        end
    endgenerate

    always_comb begin
        val = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (idx == 4'(k)) val = rom[k];
        end
    end

endmodule

// File: rtl/itrf_align.sv
module itrf_align
    import itrf_pkg::*;
(
    input  logic [63:0] val,
    input  logic [2:0]  boff,
    input  logic [1:0]  size,
    output logic [63:0] out
);

    assign out = (val >> {boff, 3'b000}) & itrf_size_mask(size);

endmodule

// File: rtl/itrf_regfront.sv
module itrf_regfront
    import itrf_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          PTR_W      = 15,
    parameter logic [7:0]  PRODUCT_ID = 8'h4B,
    parameter logic [11:0] IMPL_ID    = 12'h43B,
    parameter logic [4:0]  ID_BITS    = 5'h0F,
    parameter logic [4:0]  DEV_BITS   = 5'h0F,
    parameter logic [7:0]  HW_COLL    = 8'hFF,
    parameter logic [7:0]  PART2_VAL  = 8'h30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [63:0]       acc_wdata,
    input  logic [PTR_W-1:0]  eng_rptr,
    input  logic [PTR_W-1:0]  eng_wptr,
    input  logic              eng_fetch_busy,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              its_enable
);

    localparam logic [63:0] TYPER_VAL = 64'(1)
                                      | (64'(ID_BITS)  << 8)
                                      | (64'(DEV_BITS) << 13)
                                      | (64'(HW_COLL)  << 24);
    localparam logic [31:0] IIDR_VAL  = {PRODUCT_ID, 12'h000, IMPL_ID};

    itrf_state_t  st_d, st_q;
    itrf_region_e region;
    logic [2:0]   boff;
    logic [3:0]   id_idx;
    logic [31:0]  id_val;
    logic [63:0]  reg_val;
    logic [63:0]  aligned;
    logic         quiet;
    logic         ctrl_wr;

    itrf_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr   (acc_addr),
        .region (region),
        .boff   (boff),
        .id_idx (id_idx)
    );

    itrf_idrom #(.PART2_VAL(PART2_VAL)) i_idrom (
        .idx (id_idx),
        .val (id_val)
    );

    itrf_align i_align (
        .val  (reg_val),
        .boff (boff),
        .size (acc_size),
        .out  (aligned)
    );

    always_comb begin
        quiet   = (eng_rptr == eng_wptr) && !eng_fetch_busy;
        ctrl_wr = acc_valid && acc_write && (acc_addr == '0);
        case (region)
            RG_CTRL:  reg_val = {32'h0, quiet, 30'h0, st_q.en};
            RG_IIDR:  reg_val = {32'h0, IIDR_VAL};
            RG_TYPER: reg_val = TYPER_VAL;
            RG_IDB:   reg_val = {32'h0, id_val};
            default:  reg_val = '0;
        endcase

        st_d        = st_q;
        st_d.rvalid = acc_valid && !acc_write;
        st_d.rdata  = (acc_valid && !acc_write) ? aligned : '0;
        if (ctrl_wr) st_d.en = acc_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_valid   = st_q.rvalid;
    assign rd_data    = st_q.rdata;
    assign its_enable = st_q.en;

endmodule

// File: rtl/itrf_regfront_chk.sv
module itrf_regfront_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [15:0] acc_addr,
    input logic [1:0]  acc_size,
    input logic [63:0] acc_wdata,
    input logic [14:0] eng_rptr,
    input logic [14:0] eng_wptr,
    input logic        eng_fetch_busy,
    input logic        rd_valid,
    input logic [63:0] rd_data,
    input logic        its_enable
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!its_enable && !rd_valid));

    a_r2_enable_load: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_addr == 16'h0000) |=> (its_enable == $past(acc_wdata[0])));

    a_r3_enable_hold: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write && acc_addr == 16'h0000) |=> $stable(its_enable));

    a_r4_idle_flag: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr == 16'h0000 && acc_size >= 2'd2)
        |=> (rd_data[31] == $past(eng_rptr == eng_wptr && !eng_fetch_busy)));

    a_r5_caps_fixed: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr == 16'h0008 && acc_size == 2'd3)
        |=> (rd_data == 64'h0000_0000_FF01_EF01));

    a_r9_byte_mask: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_size == 2'd0) |=> (rd_data[63:8] == 56'h0));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> rd_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> (!rd_valid && rd_data == 64'h0));

endmodule

bind itrf_regfront itrf_regfront_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .acc_valid      (acc_valid),
    .acc_write      (acc_write),
    .acc_addr       (acc_addr),
    .acc_size       (acc_size),
    .acc_wdata      (acc_wdata),
    .eng_rptr       (eng_rptr),
    .eng_wptr       (eng_wptr),
    .eng_fetch_busy (eng_fetch_busy),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .its_enable     (its_enable)
);

// File: tb/test_itrf_regfront.sv
`timescale 1ns/1ps
module test_itrf_regfront;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [63:0] acc_wdata = '0;
    logic [14:0] eng_rptr = '0;
    logic [14:0] eng_wptr = '0;
    logic        eng_fetch_busy = 1'b0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        its_enable;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  model_en = 1'b0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    itrf_regfront i_itrf_regfront (
        .clk            (clk),
        .rst            (rst),
        .acc_valid      (acc_valid),
        .acc_write      (acc_write),
        .acc_addr       (acc_addr),
        .acc_size       (acc_size),
        .acc_wdata      (acc_wdata),
        .eng_rptr       (eng_rptr),
        .eng_wptr       (eng_wptr),
        .eng_fetch_busy (eng_fetch_busy),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .its_enable     (its_enable)
    );

    function automatic logic [63:0] model_read(input logic [15:0] a, input logic [1:0] sz,
                                               input bit en, input bit q);
        logic [63:0] w;
        int          sh;
        w  = '0;
        sh = 0;
        if (a < 16'h0004) begin
            w  = {32'h0, q, 30'h0, en};
            sh = int'(a[1:0]);
        end else if (a < 16'h0008) begin
            w  = 64'h4B00_043B;
            sh = int'(a[1:0]);
        end else if (a < 16'h0010) begin
            w  = 64'hFF01_EF01;
            sh = int'(a[2:0]);
        end else if (a >= 16'hFFD0) begin
            sh = int'(a[1:0]);
            case ({a[15:2], 2'b00})
                16'hFFD0: w = 64'h40;
                16'hFFE8: w = 64'h30;
                16'hFFF0: w = 64'h0D;
                16'hFFF4: w = 64'hF0;
                16'hFFF8: w = 64'h05;
                16'hFFFC: w = 64'hB1;
                default:  w = 64'h0;
            endcase
        end
        w = w >> (8 * sh);
        if (sz != 2'd3) w = w & ((64'h1 << (8 * (1 << sz))) - 64'h1);
        return w;
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input string req, input logic [15:0] a, input logic [1:0] sz,
                           input logic [14:0] rp, input logic [14:0] wp, input bit busy);
        logic [63:0] exp;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
        eng_rptr = rp; eng_wptr = wp; eng_fetch_busy = busy;
        exp = model_read(a, sz, model_en, (rp == wp) && !busy);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        check64({req, "/R10 valid"}, {63'h0, rd_valid}, 64'h1);
        check64(req, rd_data, exp);
    endtask

    task automatic do_write(input string req, input logic [15:0] a, input logic [1:0] sz,
                            input logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        if (a == 16'h0000) model_en = d[0];
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check64(req, {63'h0, its_enable}, {63'h0, model_en});
        check64("R10 no valid on write", {63'h0, rd_valid}, 64'h0);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pool [16];
        pool = '{16'h0000, 16'h0001, 16'h0002, 16'h0004, 16'h0006, 16'h0008, 16'h0009,
                 16'h000C, 16'h000F, 16'h0010, 16'h0100, 16'hFFD0, 16'hFFD4,
                 16'hFFE8, 16'hFFF0, 16'hFFFC};
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check64("R1 enable after reset", {63'h0, its_enable}, 64'h0);
        check64("R1 valid after reset", {63'h0, rd_valid}, 64'h0);
        do_read("R1 ctrl read", 16'h0000, 2'd2, 15'd3, 15'd3, 1'b0);

        // R2 / R4
        do_write("R2 set enable", 16'h0000, 2'd2, 64'h1);
        do_read("R4 idle", 16'h0000, 2'd2, 15'd7, 15'd7, 1'b0);
        do_read("R4 ptrs differ", 16'h0000, 2'd2, 15'd7, 15'd8, 1'b0);
        do_read("R4 fetch busy", 16'h0000, 2'd2, 15'd7, 15'd7, 1'b1);
        do_write("R3 write byte 1 ignored", 16'h0001, 2'd0, 64'h0);
        do_write("R3 write byte 3 ignored", 16'h0003, 2'd0, 64'h0);
        do_read("R3 enable kept", 16'h0000, 2'd0, 15'd1, 15'd2, 1'b0);
        do_write("R2 byte write clears", 16'h0000, 2'd0, 64'hFE);

        // R5 / R6
        do_write("R5 caps write", 16'h0008, 2'd3, 64'h0);
        do_read("R5 caps", 16'h0008, 2'd3, 15'd0, 15'd0, 1'b0);
        do_write("R6 impl write", 16'h0004, 2'd2, 64'hFFFF_FFFF);
        do_read("R6 impl", 16'h0004, 2'd2, 15'd0, 15'd0, 1'b0);

        // R7 / R8
        do_read("R7 page", 16'hFFD0, 2'd2, 15'd0, 15'd0, 1'b0);
        do_read("R7 rev", 16'hFFE8, 2'd2, 15'd0, 15'd0, 1'b0);
        do_read("R7 cid0", 16'hFFF0, 2'd2, 15'd0, 15'd0, 1'b0);
        do_read("R7 cid1", 16'hFFF4, 2'd2, 15'd0, 15'd0, 1'b0);
        do_read("R7 cid2", 16'hFFF8, 2'd2, 15'd0, 15'd0, 1'b0);
        do_read("R7 cid3", 16'hFFFC, 2'd2, 15'd0, 15'd0, 1'b0);
        do_read("R8 id gap", 16'hFFD4, 2'd2, 15'd0, 15'd0, 1'b0);
        do_read("R8 unmapped", 16'h0100, 2'd3, 15'd0, 15'd0, 1'b0);

        // R9 narrow reads
        do_read("R9 caps byte 3", 16'h000B, 2'd0, 15'd0, 15'd0, 1'b0);
        do_read("R9 caps half at 9", 16'h0009, 2'd1, 15'd0, 15'd0, 1'b0);
        do_read("R9 ctrl byte 3", 16'h0003, 2'd0, 15'd5, 15'd5, 1'b0);
        do_read("R9 ctrl dword", 16'h0000, 2'd3, 15'd5, 15'd5, 1'b0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [1:0]  sz;
            logic [14:0] rp, wp;
            bit          busy;
            a    = ($urandom_range(0, 3) == 0) ? 16'($urandom) : pool[$urandom_range(0, 15)];
            sz   = 2'($urandom_range(0, 3));
            rp   = 15'($urandom);
            wp   = ($urandom_range(0, 1) == 1) ? rp : 15'($urandom);
            busy = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 3) == 0)
                do_write("R2/R3 random write", a, sz, {$urandom, $urandom});
            else
                do_read("R9 random read", a, sz, rp, wp, busy);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule